// File: doc/BRIEF.md
# Coprocessor Transfer Handshake Sequencer

This block carries one coprocessor instruction at a time through a response-code handshake with an attached coprocessor. It accepts an instruction (a kind, a 4-bit coprocessor number, a start word address and a writeback request bit) on a valid/ready input. First it checks a presence mask. An instruction aimed at an empty slot ends at once as undefined. Otherwise the block asks the coprocessor, then keeps asking while the answer is "busy". It gives up on the instruction if an enabled interrupt is found during one of the idle cycles.

For load and store kinds, the block then moves words between a word-wide memory port and the coprocessor. A load reads memory and hands the word over. A store takes a word from the coprocessor and writes it. The address steps by one word (4 bytes) each time the coprocessor answers "increment". A memory abort ends the transfer.

Every instruction ends with a one-cycle `done` pulse. At most one outcome flag rides on that pulse: undefined, data abort or interrupt abandon. No flag means the instruction completed. A writeback request for the base register rides on the same pulse.

Stream rules: `start_valid` must hold the instruction fields stable until `start_ready`. `start_ready` is high only while the block is idle. The memory port is valid/ready: while `mem_valid` is high and `mem_ready` is low, the block holds `mem_addr`, `mem_we` and `mem_wdata` stable. `mem_rdata` and `mem_abort` are read only in the cycle where valid and ready are both high. The coprocessor port is a plain same-cycle exchange: `cp_resp` and `cp_rdata` answer `cp_req` combinationally in the same cycle.

Top module: `cp_handshake_seq`

## Requirements
- R1: When the coprocessor-present bit for `start_cp` is 0 at acceptance, the next cycle shows `done` with `exc_undef`, and the block issues no coprocessor request and no memory access.
- R2: The first request of an instruction carries phase code 0 ("first"). An answer of 1 ("busy") is followed by exactly one cycle with no request. The block then asks again with phase code 1 ("busy"). Answer codes are: 0 ready, 1 busy, 2 cannot, 3 increment.
- R3: If an interrupt is pending during that idle cycle, the next cycle carries a request with phase code 2 ("interrupt"). The cycle after that shows `done` with `exc_intr`, no writeback, and `intr_kind` naming the source.
- R4: Interrupt sources are ranked: reset line `reset_req_n` low (kind 0), then `fiq_req` with `fiq_mask` low (kind 1), then `irq_req` with `irq_mask` low (kind 2). A masked source has no effect and the wait goes on.
- R5: An answer of 2 ("cannot") to a first or busy request ends the instruction with `done` and `exc_undef`.
- R6: Kind 1 (load) reads the word at the current address. In the next cycle the block hands that word to the coprocessor on `cp_wdata` with phase code 3 ("data"). An answer of 3 repeats this at the address plus 4. Any other answer ends the instruction.
- R7: Kind 2 (store) requests a word with phase code 3. In the following memory cycle it writes `cp_rdata` at the current address. An answer of 3 to that data request repeats the sequence at the address plus 4.
- R8: A memory access accepted with `mem_abort` high ends the transfer. The next cycle shows `done` with `exc_abort`.
- R9: `wb_req` rides on `done` when `start_wb` was set, the kind is load or store, and the transfer completed. It also rides on `done` after an abort, unless `early_abort` was set. It is never raised for kind 0, undefined or interrupt endings.
- R10: `done` lasts one cycle. At most one of the three outcome flags is set, and only during `done`. After reset and after each `done`, `start_ready` is high.
- R11: While `mem_valid` is high and `mem_ready` is low, the memory request fields hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Instruction accepted (idle) |
| start_op | input | 2 | Kind: 0 register, 1 load, 2 store |
| start_cp | input | CP_W | Coprocessor number |
| start_addr | input | ADDR_W | First word address |
| start_wb | input | 1 | Base writeback requested |
| early_abort | input | 1 | Aborts suppress writeback |
| cp_present | input | 2**CP_W | One bit per attached coprocessor |
| cp_req | output | 1 | Request to the coprocessor |
| cp_sel | output | CP_W | Addressed coprocessor |
| cp_phase | output | 2 | Phase: 0 first, 1 busy, 2 interrupt, 3 data |
| cp_wdata | output | DATA_W | Word handed to the coprocessor |
| cp_resp | input | 2 | Answer: 0 ready, 1 busy, 2 cannot, 3 increment |
| cp_rdata | input | DATA_W | Word supplied by the coprocessor |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Write when 1 |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_abort | input | 1 | Access aborted |
| reset_req_n | input | 1 | Reset interrupt request, active low |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_mask | input | 1 | Masks fast interrupt |
| irq_mask | input | 1 | Masks normal interrupt |
| done | output | 1 | Instruction ended (pulse) |
| exc_undef | output | 1 | Undefined-instruction outcome |
| exc_abort | output | 1 | Data-abort outcome |
| exc_intr | output | 1 | Interrupt-abandon outcome |
| intr_kind | output | 2 | Interrupt source: 0 reset, 1 fast, 2 normal, 3 none |
| wb_req | output | 1 | Base writeback request |

## Verification
The hardest situations to reach are the interrupt test in the single idle cycle after a busy answer, and an abort on a later word of a stalled multi-word transfer. The bench scripts the coprocessor's answers one request at a time, so it can place busy answers before an interrupt check, a cannot answer after a wait, or an increment chain of any length. It holds the interrupt lines and masks at chosen combinations, which lets every priority order and every mask case reach the idle cycle. The memory model stalls each access a set number of cycles and aborts the access with a chosen index. This drives mid-transfer aborts under both writeback models, with back-pressure present.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  typedef enum logic [1:0] {PH_FIRST = 2'd0, PH_BUSY = 2'd1, PH_INTR = 2'd2, PH_DATA = 2'd3} cp_phase_e;
  typedef enum logic [1:0] {RS_READY = 2'd0, RS_BUSY = 2'd1, RS_CANT = 2'd2, RS_INC = 2'd3} cp_resp_e;
  typedef enum logic [1:0] {OP_REG = 2'd0, OP_LOAD = 2'd1, OP_STORE = 2'd2, OP_RSVD = 2'd3} cp_op_e;
  typedef enum logic [1:0] {OC_OK = 2'd0, OC_UNDEF = 2'd1, OC_ABORT = 2'd2, OC_INTR = 2'd3} outcome_e;
  typedef enum logic [1:0] {IK_RESET = 2'd0, IK_FIQ = 2'd1, IK_IRQ = 2'd2, IK_NONE = 2'd3} intr_kind_e;
endpackage

// File: rtl/cphs_irq_arb.sv
module cphs_irq_arb
  import cphs_pkg::*;
(
  input  logic       reset_req_n,
  input  logic       fiq_req,
  input  logic       irq_req,
  input  logic       fiq_mask,
  input  logic       irq_mask,
  output logic       pending,
  output intr_kind_e kind
);
  logic fiq_live, irq_live;

  assign fiq_live = fiq_req && !fiq_mask;
  assign irq_live = irq_req && !irq_mask;
  assign pending  = !reset_req_n || fiq_live || irq_live;

  always_comb begin
    if (!reset_req_n)  kind = IK_RESET;
    else if (fiq_live) kind = IK_FIQ;
    else if (irq_live) kind = IK_IRQ;
    else               kind = IK_NONE;
  end
endmodule

// File: rtl/cphs_addr_ctr.sv
module cphs_addr_ctr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + STEP_V;
  end
endmodule

// File: rtl/cphs_outcome.sv
module cphs_outcome
  import cphs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin,
  input  outcome_e   fin_oc,
  input  intr_kind_e fin_kind,
  input  logic       fin_wb,
  output logic       done,
  output logic       exc_undef,
  output logic       exc_abort,
  output logic       exc_intr,
  output logic [1:0] intr_kind,
  output logic       wb_req
);
  logic       done_q, wb_q;
  outcome_e   oc_q;
  intr_kind_e kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wb_q   <= 1'b0;
      oc_q   <= OC_OK;
      kind_q <= IK_NONE;
    end else begin
      done_q <= fin;
      if (fin) begin
        oc_q   <= fin_oc;
        wb_q   <= fin_wb;
        kind_q <= (fin_oc == OC_INTR) ? fin_kind : IK_NONE;
      end
    end
  end

  assign done      = done_q;
  assign exc_undef = done_q && (oc_q == OC_UNDEF);
  assign exc_abort = done_q && (oc_q == OC_ABORT);
  assign exc_intr  = done_q && (oc_q == OC_INTR);
  assign intr_kind = done_q ? kind_q : IK_NONE;
  assign wb_req    = done_q && wb_q;

  // the outcome flags are mutually exclusive and never outlive the pulse
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_undef, exc_abort, exc_intr}));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fin |=> !done);
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cphs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CP_W   = 4,
  localparam int NUM_CP = 1 << CP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [1:0]        start_op,
  input  logic [CP_W-1:0]   start_cp,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_wb,
  input  logic              early_abort,
  input  logic [NUM_CP-1:0] cp_present,
  output logic              cp_req,
  output logic [CP_W-1:0]   cp_sel,
  output logic [1:0]        cp_phase,
  output logic [DATA_W-1:0] cp_wdata,
  input  logic [1:0]        cp_resp,
  input  logic [DATA_W-1:0] cp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_abort,
  input  logic              reset_req_n,
  input  logic              fiq_req,
  input  logic              irq_req,
  input  logic              fiq_mask,
  input  logic              irq_mask,
  output logic              done,
  output logic              exc_undef,
  output logic              exc_abort,
  output logic              exc_intr,
  output logic [1:0]        intr_kind,
  output logic              wb_req
);
  localparam int STEP = DATA_W / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ASK, S_WAIT, S_ABANDON, S_LD_MEM, S_LD_DATA, S_ST_DATA, S_ST_MEM, S_DONE
  } state_e;

  state_e      state, nxt;
  cp_op_e      op_q;
  logic [CP_W-1:0]   cp_q;
  logic        wbit_q, early_q, asked_q, more_q;
  logic [DATA_W-1:0] word_q;
  intr_kind_e  kind_q;

  logic        arb_pending;
  intr_kind_e  arb_kind;
  logic        addr_load, addr_step;
  logic [ADDR_W-1:0] addr;
  logic        fin, fin_wb, cap_mem, cap_cp;
  outcome_e    fin_oc;
  cp_resp_e    resp;
  logic        xfer_op;

  assign resp    = cp_resp_e'(cp_resp);
  assign xfer_op = (op_q == OP_LOAD) || (op_q == OP_STORE);

  cphs_irq_arb u_arb (
    .reset_req_n (reset_req_n),
    .fiq_req     (fiq_req),
    .irq_req     (irq_req),
    .fiq_mask    (fiq_mask),
    .irq_mask    (irq_mask),
    .pending     (arb_pending),
    .kind        (arb_kind)
  );

  cphs_addr_ctr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_load),
    .load_val (start_addr),
    .step     (addr_step),
    .addr     (addr)
  );

  cphs_outcome u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .fin_oc    (fin_oc),
    .fin_kind  (kind_q),
    .fin_wb    (fin_wb),
    .done      (done),
    .exc_undef (exc_undef),
    .exc_abort (exc_abort),
    .exc_intr  (exc_intr),
    .intr_kind (intr_kind),
    .wb_req    (wb_req)
  );

  // next-state and handshake decode
  always_comb begin
    nxt         = state;
    start_ready = 1'b0;
    cp_req      = 1'b0;
    cp_phase    = PH_FIRST;
    mem_valid   = 1'b0;
    mem_we      = 1'b0;
    addr_load   = 1'b0;
    addr_step   = 1'b0;
    fin         = 1'b0;
    fin_oc      = OC_OK;
    fin_wb      = 1'b0;
    cap_mem     = 1'b0;
    cap_cp      = 1'b0;
    unique case (state)
      S_IDLE: begin
        start_ready = 1'b1;
        if (start_valid) begin
          addr_load = 1'b1;
          if (!cp_present[start_cp]) begin
            fin    = 1'b1;
            fin_oc = OC_UNDEF;
          end else begin
            nxt = S_ASK;
          end
        end
      end
      S_ASK: begin
        cp_req   = 1'b1;
        cp_phase = asked_q ? PH_BUSY : PH_FIRST;
        if (resp == RS_BUSY) begin
          nxt = S_WAIT;
        end else if (resp == RS_CANT) begin
          fin    = 1'b1;
          fin_oc = OC_UNDEF;
        end else if (op_q == OP_LOAD) begin
          nxt = S_LD_MEM;
        end else if (op_q == OP_STORE) begin
          nxt = S_ST_DATA;
        end else begin
          fin = 1'b1;
        end
      end
      S_WAIT: begin
        nxt = arb_pending ? S_ABANDON : S_ASK;
      end
      S_ABANDON: begin
        cp_req   = 1'b1;
        cp_phase = PH_INTR;
        fin      = 1'b1;
        fin_oc   = OC_INTR;
      end
      S_LD_MEM: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (mem_abort) begin
            fin    = 1'b1;
            fin_oc = OC_ABORT;
            fin_wb = wbit_q && !early_q;
          end else begin
            cap_mem = 1'b1;
            nxt     = S_LD_DATA;
          end
        end
      end
      S_LD_DATA: begin
        cp_req   = 1'b1;
        cp_phase = PH_DATA;
        if (resp == RS_INC) begin
          addr_step = 1'b1;
          nxt       = S_LD_MEM;
        end else begin
          fin    = 1'b1;
          fin_wb = wbit_q;
        end
      end
      S_ST_DATA: begin
        cp_req   = 1'b1;
        cp_phase = PH_DATA;
        cap_cp   = 1'b1;
        nxt      = S_ST_MEM;
      end
      S_ST_MEM: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        if (mem_ready) begin
          if (mem_abort) begin
            fin    = 1'b1;
            fin_oc = OC_ABORT;
            fin_wb = wbit_q && !early_q;
          end else if (more_q) begin
            addr_step = 1'b1;
            nxt       = S_ST_DATA;
          end else begin
            fin    = 1'b1;
            fin_wb = wbit_q;
          end
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_REG;
      cp_q    <= '0;
      wbit_q  <= 1'b0;
      early_q <= 1'b0;
      asked_q <= 1'b0;
      more_q  <= 1'b0;
      word_q  <= '0;
      kind_q  <= IK_NONE;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start_valid) begin
        op_q    <= cp_op_e'(start_op);
        cp_q    <= start_cp;
        wbit_q  <= start_wb;
        early_q <= early_abort;
        asked_q <= 1'b0;
      end
      if (state == S_WAIT) begin
        asked_q <= 1'b1;
        kind_q  <= arb_kind;
      end
      if (cap_mem) word_q <= mem_rdata;
      if (cap_cp) begin
        word_q <= cp_rdata;
        more_q <= (resp == RS_INC);
      end
    end
  end

  assign cp_sel    = cp_q;
  assign cp_wdata  = word_q;
  assign mem_addr  = addr;
  assign mem_wdata = word_q;

  // R1: an empty slot ends the instruction as undefined in the next cycle
  assert_absent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && !cp_present[start_cp] |=> done && exc_undef && !cp_req);
  // R2: a busy answer to a first/busy request leaves the next cycle quiet
  assert_busy_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && (cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RS_BUSY
    |=> !cp_req && !mem_valid && !done);
  // R3: an interrupt phase is followed by the abandon outcome without writeback
  assert_abandon_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && cp_phase == PH_INTR |=> done && exc_intr && !wb_req);
  // R5: a refusal after the wait is undefined
  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && (cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RS_CANT
    |=> done && exc_undef);
  // R6: an increment after a load data phase reads the next word
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && cp_phase == PH_DATA && cp_resp == RS_INC && op_q == OP_LOAD
    |=> mem_valid && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(STEP));
  // R8: an aborted access ends with the data-abort outcome
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_abort |=> done && exc_abort);
  // R9: register-kind instructions never request writeback
  assert_nowb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> xfer_op);
  // R11: a stalled memory request stays put
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/tb_cp_handshake_seq.sv
module tb_cp_handshake_seq;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start_valid = 1'b0, start_ready;
  logic [1:0]    start_op = 2'd0;
  logic [3:0]    start_cp = 4'd0;
  logic [AW-1:0] start_addr = '0;
  logic          start_wb = 1'b0, early_abort = 1'b0;
  logic [15:0]   cp_present = '0;
  logic          cp_req;
  logic [3:0]    cp_sel;
  logic [1:0]    cp_phase, cp_resp;
  logic [DW-1:0] cp_wdata, cp_rdata;
  logic          mem_valid, mem_ready, mem_we, mem_abort;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          reset_req_n = 1'b1, fiq_req = 1'b0, irq_req = 1'b0, fiq_mask = 1'b0, irq_mask = 1'b0;
  logic          done, exc_undef, exc_abort, exc_intr, wb_req;
  logic [1:0]    intr_kind;

  cp_handshake_seq dut (.*);

  int checks = 0, errors = 0;

  // scenario
  logic [1:0] script [0:15];
  int script_n = 0, cfg_stall = 0, cfg_abort_idx = -1;
  int ridx = 0, acc_idx = 0, stall_cnt = 0;
  bit clr_ctr = 0;

  function automatic logic [DW-1:0] memf(logic [AW-1:0] a);
    return a ^ 32'hA5A5_0F0F;
  endfunction

  assign cp_resp   = (ridx < script_n) ? script[ridx] : 2'd0;
  assign cp_rdata  = 32'h5000_0000 + 32'(ridx);
  assign mem_ready = mem_valid && (stall_cnt >= cfg_stall);
  assign mem_abort = mem_ready && (acc_idx == cfg_abort_idx);
  assign mem_rdata = memf(mem_addr);

  always @(posedge clk) begin
    if (clr_ctr) begin
      ridx <= 0; acc_idx <= 0; stall_cnt <= 0;
    end else begin
      if (cp_req) ridx <= ridx + 1;
      if (mem_valid && mem_ready) begin acc_idx <= acc_idx + 1; stall_cnt <= 0; end
      else if (mem_valid) stall_cnt <= stall_cnt + 1;
    end
  end

  typedef struct {
    bit req; logic [1:0] ph; bit mv; bit mwe; logic [31:0] ma; logic [31:0] mwd;
    logic [31:0] cwd; bit dn; logic [1:0] oc; logic [1:0] kd; bit wb;
  } exp_t;
  exp_t expq[$];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic add(bit req, logic [1:0] ph, bit mv, bit mwe, logic [31:0] ma, logic [31:0] mwd,
                     logic [31:0] cwd, bit dn, logic [1:0] oc, logic [1:0] kd, bit wb);
    exp_t e;
    e.req = req; e.ph = ph; e.mv = mv; e.mwe = mwe; e.ma = ma; e.mwd = mwd;
    e.cwd = cwd; e.dn = dn; e.oc = oc; e.kd = kd; e.wb = wb;
    expq.push_back(e);
  endtask

  function automatic logic [1:0] resp_at(int i);
    return (i < script_n) ? script[i] : 2'd0;
  endfunction

  // behavioural reference: expected per-cycle activity after acceptance
  task automatic build(logic [1:0] op, logic [3:0] cp, logic [31:0] a0, bit wb, bit early);
    int ri = 0, acc = 0;
    bit asked = 0;
    logic [31:0] a = a0;
    logic [1:0] r, kd;
    bit pend;
    expq.delete();
    if (!cp_present[cp]) begin add(0,0,0,0,0,0,0,1,2'd1,2'd3,0); return; end
    pend = !reset_req_n || (fiq_req && !fiq_mask) || (irq_req && !irq_mask);
    kd = !reset_req_n ? 2'd0 : (fiq_req && !fiq_mask) ? 2'd1 : 2'd2;
    forever begin
      r = resp_at(ri); ri++;
      add(1, asked ? 2'd1 : 2'd0, 0,0,0,0,0,0,0,0,0);
      if (r == 2'd1) begin
        add(0,0,0,0,0,0,0,0,0,0,0);
        if (pend) begin add(1,2'd2,0,0,0,0,0,0,0,0,0); add(0,0,0,0,0,0,0,1,2'd3,kd,0); return; end
        asked = 1;
      end else if (r == 2'd2) begin
        add(0,0,0,0,0,0,0,1,2'd1,2'd3,0); return;
      end else break;
    end
    if (op == 2'd1) begin
      forever begin
        for (int s = 0; s < cfg_stall; s++) add(0,0,1,0,a,0,0,0,0,0,0);
        add(0,0,1,0,a,0,0,0,0,0,0);
        if (acc == cfg_abort_idx) begin add(0,0,0,0,0,0,0,1,2'd2,2'd3,wb && !early); return; end
        acc++;
        r = resp_at(ri); ri++;
        add(1,2'd3,0,0,0,0,memf(a),0,0,0,0);
        if (r == 2'd3) a = a + 4;
        else begin add(0,0,0,0,0,0,0,1,2'd0,2'd3,wb); return; end
      end
    end else if (op == 2'd2) begin
      forever begin
        logic [31:0] d;
        r = resp_at(ri); d = 32'h5000_0000 + 32'(ri); ri++;
        add(1,2'd3,0,0,0,0,0,0,0,0,0);
        for (int s = 0; s < cfg_stall; s++) add(0,0,1,1,a,d,0,0,0,0,0);
        add(0,0,1,1,a,d,0,0,0,0,0);
        if (acc == cfg_abort_idx) begin add(0,0,0,0,0,0,0,1,2'd2,2'd3,wb && !early); return; end
        acc++;
        if (r == 2'd3) a = a + 4;
        else begin add(0,0,0,0,0,0,0,1,2'd0,2'd3,wb); return; end
      end
    end else begin
      add(0,0,0,0,0,0,0,1,2'd0,2'd3,0);
    end
  endtask

  // run one instruction, compare every cycle against the reference
  task automatic run(string tag, logic [1:0] op, logic [3:0] cp, logic [31:0] a0, bit wb, bit early);
    int cyc = 0;
    build(op, cp, a0, wb, early);
    @(negedge clk);
    chk(start_ready === 1'b1, tag, "start_ready idle (R10)", 32'(start_ready), 1);
    start_valid = 1; start_op = op; start_cp = cp; start_addr = a0; start_wb = wb; early_abort = early;
    clr_ctr = 1;
    while (expq.size() > 0 && cyc < 200) begin
      exp_t e;
      @(negedge clk);
      clr_ctr = 0; start_valid = 0; cyc++;
      e = expq.pop_front();
      chk(cp_req === e.req, tag, "cp_req", 32'(cp_req), 32'(e.req));
      if (e.req) begin
        chk(cp_phase === e.ph, tag, "cp_phase", 32'(cp_phase), 32'(e.ph));
        chk(cp_sel === cp, tag, "cp_sel", 32'(cp_sel), 32'(cp));
        if (e.ph == 2'd3 && op == 2'd1) chk(cp_wdata === e.cwd, tag, "cp_wdata (R6)", cp_wdata, e.cwd);
      end
      chk(mem_valid === e.mv, tag, "mem_valid", 32'(mem_valid), 32'(e.mv));
      if (e.mv) begin
        chk(mem_addr === e.ma, tag, "mem_addr", mem_addr, e.ma);
        chk(mem_we === e.mwe, tag, "mem_we", 32'(mem_we), 32'(e.mwe));
        if (e.mwe) chk(mem_wdata === e.mwd, tag, "mem_wdata (R7)", mem_wdata, e.mwd);
      end
      chk(done === e.dn, tag, "done", 32'(done), 32'(e.dn));
      chk(start_ready === 1'b0, tag, "start_ready busy (R10)", 32'(start_ready), 0);
      if (e.dn) begin
        chk(exc_undef === (e.oc == 2'd1), tag, "exc_undef", 32'(exc_undef), 32'(e.oc == 2'd1));
        chk(exc_abort === (e.oc == 2'd2), tag, "exc_abort", 32'(exc_abort), 32'(e.oc == 2'd2));
        chk(exc_intr === (e.oc == 2'd3), tag, "exc_intr", 32'(exc_intr), 32'(e.oc == 2'd3));
        chk(intr_kind === e.kd, tag, "intr_kind", 32'(intr_kind), 32'(e.kd));
        chk(wb_req === e.wb, tag, "wb_req (R9)", 32'(wb_req), 32'(e.wb));
      end
    end
    @(negedge clk);
    chk(done === 1'b0, tag, "done pulse ends (R10)", 32'(done), 0);
    chk(start_ready === 1'b1, tag, "start_ready after done (R10)", 32'(start_ready), 1);
  endtask

  task automatic set_script(int n, logic [1:0] s0, logic [1:0] s1, logic [1:0] s2, logic [1:0] s3, logic [1:0] s4);
    script[0] = s0; script[1] = s1; script[2] = s2; script[3] = s3; script[4] = s4;
    script_n = n;
  endtask

  task automatic set_irq(bit rn, bit f, bit i, bit fm, bit im);
    reset_req_n = rn; fiq_req = f; irq_req = i; fiq_mask = fm; irq_mask = im;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) script[k] = 2'd0;
    cp_present = 16'b1000_0000_1101_1111;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(start_ready === 1 && done === 0 && cp_req === 0 && mem_valid === 0 && wb_req === 0,
        "R10", "reset state", {start_ready, done, cp_req, mem_valid}, 32'h8);

    set_script(0, 0,0,0,0,0);
    run("R1", 2'd1, 4'd5, 32'h100, 1, 0);              // slot 5 empty
    set_script(1, 0,0,0,0,0);
    run("R2_ready", 2'd0, 4'd15, 32'h0, 1, 0);         // highest slot, reg kind, wb ignored (R9)
    set_script(3, 1,1,0,0,0);
    run("R2_busy", 2'd0, 4'd0, 32'h0, 0, 0);
    set_script(3, 1,1,2,0,0);
    run("R5", 2'd0, 4'd1, 32'h0, 0, 0);
    set_script(2, 2,0,0,0,0);
    run("R5_first", 2'd1, 4'd2, 32'h40, 1, 0);
    set_irq(1, 0, 1, 0, 0);
    set_script(2, 1,0,0,0,0);
    run("R3_irq", 2'd1, 4'd3, 32'h40, 1, 0);
    set_irq(1, 1, 1, 1, 1);
    set_script(3, 1,1,0,0,0);
    run("R4_masked", 2'd0, 4'd3, 32'h0, 0, 0);
    set_irq(0, 1, 1, 0, 0);
    set_script(2, 1,0,0,0,0);
    run("R4_reset", 2'd2, 4'd4, 32'h0, 1, 0);
    set_irq(1, 1, 1, 0, 0);
    run("R4_fiq", 2'd0, 4'd4, 32'h0, 0, 0);
    set_irq(1, 1, 1, 1, 0);
    run("R4_irq_under_masked_fiq", 2'd0, 4'd4, 32'h0, 0, 0);
    set_irq(1, 0, 0, 0, 0);

    cfg_stall = 0; cfg_abort_idx = -1;
    set_script(4, 0,3,3,0,0);
    run("R6_load3", 2'd1, 4'd6, 32'h0000_1000, 1, 0);
    cfg_stall = 2;
    set_script(5, 1,0,3,3,1);
    run("R11_load_stall", 2'd1, 4'd6, 32'h0000_2FF8, 0, 0);
    cfg_stall = 0;
    set_script(3, 0,3,0,0,0);
    run("R7_store2", 2'd2, 4'd7, 32'h0000_3000, 1, 0);
    cfg_stall = 1;
    set_script(4, 3,3,3,2,0);
    run("R7_store_stall", 2'd2, 4'd7, 32'h0000_3100, 0, 0);
    cfg_stall = 1; cfg_abort_idx = 1;
    set_script(4, 0,3,3,0,0);
    run("R8_load_abort_late", 2'd1, 4'd6, 32'h0000_4000, 1, 0);
    cfg_stall = 0; cfg_abort_idx = 0;
    set_script(3, 0,3,0,0,0);
    run("R9_store_abort_early", 2'd2, 4'd7, 32'h0000_5000, 1, 1);
    cfg_abort_idx = -1;
    set_script(2, 0,0,0,0,0);
    run("R9_load_early_noabort", 2'd1, 4'd6, 32'h0000_6000, 1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule